// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps one atomic reservation for a 32-bit core. A load-reserve request arms the reservation and records its effective address. A later store-conditional to the same address succeeds only while that reservation is still armed. The monitor reports the outcome on a condition flag and produces the write-enable, address and data that gate the memory write.

Every conditional store disarms the reservation, whether it succeeds or fails. An ordinary store also disarms it when its address, masked to a word inside the low 28-bit window, equals the recorded address. The core computes all addresses, and the memory sits outside the block. Load-reserve, store-conditional and ordinary-store requests each come in on their own valid-qualified channel, and all three may be active in the same cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `sc_ok_o` and `mem_we_o` are 0 and no reservation is held: the reserved address is 0 and the armed flag is 0, so a first conditional store, even one to address 0, fails.
- R2: A load-reserve arms the reservation and records `lr_addr_i` as the reserved address.
- R3: A conditional store succeeds exactly when the reservation is armed and `sc_addr_i` equals the reserved address in all 32 bits. The check uses the state from before that cycle's updates.
- R4: `mem_we_o` is 1 only in the cycle after a successful conditional store. In that cycle `mem_waddr_o` and `mem_wdata_o` carry that store's address and data.
- R5: Every conditional store disarms the reservation, so a second conditional store with no new load-reserve fails.
- R6: An ordinary store disarms the reservation when (`st_addr_i` AND 0x0FFFFFFC) equals the reserved address. This includes byte and halfword offsets inside the reserved word.
- R7: An ordinary store whose masked address differs leaves the reservation unchanged. A reserved address with any of bits 31..28 set is therefore never cleared by an ordinary store.
- R8: When a load-reserve arrives in the same cycle as a conditional store or a matching ordinary store, the load-reserve wins and the reservation ends up armed with the new address.
- R9: `sc_ok_o` changes only one cycle after a conditional store and holds its value in between. `mem_we_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lr_valid_i | input | 1 | Load-reserve request |
| lr_addr_i | input | 32 | Load-reserve effective address |
| sc_valid_i | input | 1 | Store-conditional request |
| sc_addr_i | input | 32 | Store-conditional effective address |
| sc_data_i | input | 32 | Store-conditional write data |
| st_valid_i | input | 1 | Ordinary store event (any size) |
| st_addr_i | input | 32 | Ordinary store address |
| sc_ok_o | output | 1 | Condition flag from the last conditional store |
| mem_we_o | output | 1 | Memory write-enable for the conditional store |
| mem_waddr_o | output | 32 | Conditional store write address |
| mem_wdata_o | output | 32 | Conditional store write data |

## Verification
`sc_ok_o`, `mem_we_o` and the write address and data are registered, so they are due at the first rising edge after the conditional-store cycle. Reservation updates take effect at that same edge and only show in the result of the next conditional store. The bench drives each request on a falling edge and lets one rising edge pass. It then compares against its own model at the following falling edge, so every comparison falls exactly one register stage after its stimulus.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam logic [31:0] DEF_ST_MASK = 32'h0FFF_FFFC;

  typedef enum logic [1:0] {
    RSV_HOLD  = 2'd0,
    RSV_ARM   = 2'd1,
    RSV_CLEAR = 2'd2
  } rsv_act_e;
endpackage

// File: rtl/lrsc_store_match.sv
module lrsc_store_match #(
  parameter int unsigned ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] ST_MASK = '1
) (
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [ADDR_W-1:0] rsv_addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] masked;
  assign masked = st_addr_i & ST_MASK;
  assign hit_o  = st_valid_i && (masked == rsv_addr_i);
endmodule

// File: rtl/lrsc_rsv_state.sv
module lrsc_rsv_state
  import lrsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_valid_i,
  input  logic [ADDR_W-1:0] lr_addr_i,
  input  logic              clr_i,
  output logic              rsv_flag_o,
  output logic [ADDR_W-1:0] rsv_addr_o
);
  rsv_act_e act;

  // load-reserve outranks any clearing event
  always_comb begin
    if (lr_valid_i)  act = RSV_ARM;
    else if (clr_i)  act = RSV_CLEAR;
    else             act = RSV_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_flag_o <= 1'b0;
      rsv_addr_o <= '0;
    end else begin
      unique case (act)
        RSV_ARM: begin
          rsv_flag_o <= 1'b1;
          rsv_addr_o <= lr_addr_i;
        end
        RSV_CLEAR: rsv_flag_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // R8
  lr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_valid_i |=> rsv_flag_o && (rsv_addr_o == $past(lr_addr_i)));

  // R5
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !lr_valid_i) |=> !rsv_flag_o);

  // R7
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !lr_valid_i) |=> $stable(rsv_flag_o) && $stable(rsv_addr_o));
endmodule

// File: rtl/lrsc_sc_result.sv
module lrsc_sc_result #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [DATA_W-1:0] sc_data_i,
  input  logic              rsv_flag_i,
  input  logic [ADDR_W-1:0] rsv_addr_i,
  output logic              ok_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic ok_d;
  logic armed_q;

  assign ok_d = rsv_flag_i && (sc_addr_i == rsv_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o    <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      we_o    <= sc_valid_i && ok_d;
      if (sc_valid_i) begin
        ok_o    <= ok_d;
        waddr_o <= sc_addr_i;
        wdata_o <= sc_data_i;
      end
    end
  end

  // R3
  no_rsv_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && !rsv_flag_i) |=> !ok_o);

  // R4
  we_needs_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ok_o);

  // R9
  ok_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !sc_valid_i) |=> $stable(ok_o) && !we_o);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] ST_MASK = ADDR_W'(DEF_ST_MASK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_valid_i,
  input  logic [ADDR_W-1:0] lr_addr_i,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [DATA_W-1:0] sc_data_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              sc_ok_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              rsv_flag;
  logic [ADDR_W-1:0] rsv_addr;
  logic              st_hit;
  logic              clr;

  lrsc_store_match #(.ADDR_W(ADDR_W), .ST_MASK(ST_MASK)) u_match (
    .st_valid_i (st_valid_i),
    .st_addr_i  (st_addr_i),
    .rsv_addr_i (rsv_addr),
    .hit_o      (st_hit)
  );

  assign clr = sc_valid_i || st_hit;

  lrsc_rsv_state #(.ADDR_W(ADDR_W)) u_rsv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lr_valid_i (lr_valid_i),
    .lr_addr_i  (lr_addr_i),
    .clr_i      (clr),
    .rsv_flag_o (rsv_flag),
    .rsv_addr_o (rsv_addr)
  );

  lrsc_sc_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sc_valid_i (sc_valid_i),
    .sc_addr_i  (sc_addr_i),
    .sc_data_i  (sc_data_i),
    .rsv_flag_i (rsv_flag),
    .rsv_addr_i (rsv_addr),
    .ok_o       (sc_ok_o),
    .we_o       (mem_we_o),
    .waddr_o    (mem_waddr_o),
    .wdata_o    (mem_wdata_o)
  );

  // R6
  st_hit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && ((st_addr_i & ST_MASK) == rsv_addr) && !lr_valid_i) |=> !rsv_flag);
endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;
  localparam logic [31:0] MASK = 32'h0FFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lr_v = 1'b0, sc_v = 1'b0, st_v = 1'b0;
  logic [31:0] lr_a = '0, sc_a = '0, sc_d = '0, st_a = '0;
  logic        sc_ok, mem_we;
  logic [31:0] mem_waddr, mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic        m_flag = 1'b0;
  logic [31:0] m_addr = '0;
  logic        m_ok = 1'b0, m_we = 1'b0;
  logic [31:0] m_wa = '0, m_wd = '0;

  always #2 clk = ~clk;

  lrsc_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lr_valid_i(lr_v), .lr_addr_i(lr_a),
    .sc_valid_i(sc_v), .sc_addr_i(sc_a), .sc_data_i(sc_d),
    .st_valid_i(st_v), .st_addr_i(st_a),
    .sc_ok_o(sc_ok), .mem_we_o(mem_we),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  function automatic logic exp_ok(logic f, logic [31:0] ra, logic [31:0] a);
    return f && (a == ra);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit lr, logic [31:0] la, bit sc, logic [31:0] sa, logic [31:0] sd,
                      bit st, logic [31:0] ta, string tag);
    logic ok;
    lr_v = lr; lr_a = la; sc_v = sc; sc_a = sa; sc_d = sd; st_v = st; st_a = ta;
    @(posedge clk);
    ok = exp_ok(m_flag, m_addr, sa);
    m_we = sc && ok;
    if (sc) begin m_ok = ok; m_wa = sa; m_wd = sd; end
    if (lr) begin m_flag = 1'b1; m_addr = la; end
    else if (sc || (st && ((ta & MASK) == m_addr))) m_flag = 1'b0;
    @(negedge clk);
    lr_v = 1'b0; sc_v = 1'b0; st_v = 1'b0;
    chk(tag, "sc_ok", 32'(sc_ok), 32'(m_ok));
    chk(tag, "mem_we", 32'(mem_we), 32'(m_we));
    if (m_we) begin
      chk(tag, "mem_waddr", mem_waddr, m_wa);
      chk(tag, "mem_wdata", mem_wdata, m_wd);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sc_ok in reset", 32'(sc_ok), 0);
    chk("R1", "mem_we in reset", 32'(mem_we), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(0, 0, 1, 32'h0, 32'hAAAA_0001, 0, 0, "R1");               // no reservation at addr 0
    step(1, 32'h200, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 32'h200, 32'hDEAD_BEEF, 0, 0, "R2");             // succeeds
    step(0, 0, 0, 0, 0, 0, 0, "R9");                               // flag holds, we drops
    step(0, 0, 1, 32'h200, 32'h1111_1111, 0, 0, "R5");             // fails: already consumed
    step(1, 32'h200, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 32'h204, 32'h2222_2222, 0, 0, "R3");             // wrong address
    step(0, 0, 1, 32'h200, 32'h3333_3333, 0, 0, "R5");             // failed sc still cleared
    step(1, 32'h300, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 32'h302, "R6");                         // byte store in word
    step(0, 0, 1, 32'h300, 32'h4444_4444, 0, 0, "R6");
    step(1, 32'h300, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 32'h400, "R7");
    step(0, 0, 1, 32'h300, 32'h5555_5555, 0, 0, "R7");             // succeeds
    step(1, 32'h1000_0300, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 32'h1000_0300, "R7");                   // mask hides top nibble
    step(0, 0, 1, 32'h1000_0300, 32'h6666_6666, 0, 0, "R7");       // succeeds
    step(1, 32'h300, 0, 0, 0, 1, 32'h300, "R8");                   // lr beats store
    step(0, 0, 1, 32'h300, 32'h7777_7777, 0, 0, "R8");             // succeeds
    step(1, 32'h500, 1, 32'h500, 32'h8888_8888, 0, 0, "R8");       // sc sees old state: fails
    step(0, 0, 1, 32'h500, 32'h9999_9999, 0, 0, "R8");             // new reservation: succeeds
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    // random mix, R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pool [4];
      pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h1000_0100; pool[3] = 32'h108;
      step(($urandom % 4) == 0, pool[$urandom % 4],
           ($urandom % 3) == 0, pool[$urandom % 4], $urandom,
           ($urandom % 4) == 0, pool[$urandom % 4] | 32'($urandom % 4),
           "R4");
    end
    finish_run();
  end
endmodule